// File: doc/BRIEF.md
# Serial-Link Master Port-Enable Register Bank

This block is the memory-mapped control bank of a serial-link master. A host reaches it through a single-cycle, word-organised register port: a byte address, a write strobe with write data, and a read strobe whose data comes back one clock later. The bank holds two 32-bit port-enable words. Software can overwrite each of them, set individual bits through a set alias, or clear individual bits through a clear alias. It does this without a read-modify-write sequence.

Around those two words sit four other kinds of location. The first is a version word with a fixed power-up value, which software may overwrite. The second is an error-status word that ignores writes and always reports zero. The third is a command word: writing it with either of its two top bits set returns the whole bank to its power-up state on that clock edge. The last kind is plain read/write scratch storage at every other implemented word. Accesses past the last implemented word read zero and write nothing.

Top module: `pen_ctrl_regs`

## Requirements
- R1: After reset every word reads zero, except the version word at byte offset 0x074, which reads 0xE0050101.
- R2: A write to byte offset 0x010 (enable word 0) or 0x014 (enable word 1) replaces that word with the write data.
- R3: A write to 0x018 ORs the data into enable word 0, and a write to 0x01C ORs it into enable word 1.
- R4: A write to 0x020 clears, in enable word 0, each bit that is 1 in the data. A write to 0x024 does the same for enable word 1.
- R5: Reads of the alias offsets 0x018, 0x01C, 0x020 and 0x024 always return zero, whatever was written there.
- R6: Writes to the error-status offset 0x0D0 are discarded, and that offset always reads zero.
- R7: A write to the command offset 0x1D0 with bit 31 or bit 30 of the data set puts every word back to its R1 value at the clock edge that samples the write. The command word itself is never stored, and it reads zero. A write to that offset with neither bit set changes nothing.
- R8: Every other offset from 0x000 to 0x1FC, including the version word, stores the written word and reads it back unchanged.
- R9: A read at a byte address of 0x200 or above returns zero. A write there changes no word in the bank, including the word whose low address bits it shares.
- R10: Read data appears on the clock edge after the read strobe and holds until the next read. A read and a write to the same word in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 16 | Byte address of the access; bits 1:0 are ignored |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, registered |

## Verification
The enable words are driven with patterns whose set and clear masks partly overlap the bits already present. A result that is simply replaced can then be told apart from one that is ORed or AND-NOTed in. The command word is written three ways: with bit 31 only, with bit 30 only, and with a low bit only. This separates a true bank reset from a write that is ignored or stored. Out-of-range writes use addresses whose low bits alias an enable word, which exposes any truncated decode. A same-cycle read and write of one scratch word separates old-value read data from new-value read data.

// File: rtl/pen_regs_pkg.sv
`timescale 1ns/1ps
package pen_regs_pkg;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_PLAIN,
      OP_SET,
      OP_CLR,
      OP_DROP,
      OP_SRST
   } wr_op_e;

   // word indices (byte offset >> 2)
   localparam int unsigned W_EN0     = 4;
   localparam int unsigned N_EN      = 2;
   localparam int unsigned SET_DIST  = 2;   // set alias sits this many words above its enable word
   localparam int unsigned CLR_DIST  = 4;   // clear alias distance
   localparam int unsigned W_VER     = 29;  // 0x074
   localparam int unsigned W_ERRSTAT = 52;  // 0x0D0
   localparam int unsigned W_CMD     = 116; // 0x1D0

   function automatic bit is_alias(input int unsigned i);
      return (i >= W_EN0 + SET_DIST) && (i < W_EN0 + CLR_DIST + N_EN);
   endfunction

   function automatic bit is_zero_word(input int unsigned i);
      return is_alias(i) || (i == W_ERRSTAT) || (i == W_CMD);
   endfunction

   function automatic bit is_en_word(input int unsigned i);
      return (i >= W_EN0) && (i < W_EN0 + N_EN);
   endfunction

endpackage

// File: rtl/pen_addr_decode.sv
`timescale 1ns/1ps
module pen_addr_decode
   import pen_regs_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned NWORDS  = 128,
   parameter int unsigned IDX_W   = 7,
   parameter int unsigned CMD_HI  = 31,
   parameter int unsigned CMD_LO  = 30
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [IDX_W-1:0]  idx,
   output logic              in_range,
   output wr_op_e            op
);

   localparam int unsigned TOP_BITS = ADDR_W - IDX_W - 2;

   if (IDX_W != $clog2(NWORDS))  $error("IDX_W must equal clog2(NWORDS)");
   if (ADDR_W < IDX_W + 2)       $error("ADDR_W too narrow for NWORDS");
   if (CMD_HI >= DATA_W || CMD_LO >= DATA_W) $error("command bits outside data");

   assign idx = addr[IDX_W+1:2];

   // range check variant chosen by whether the address has bits above the bank
   if (TOP_BITS == 0) begin : g_full
      assign in_range = 1'b1;
   end else begin : g_upper
      assign in_range = (addr[ADDR_W-1:IDX_W+2] == '0);
   end

   logic is_set, is_clr;
   always_comb begin
      is_set = 1'b0;
      is_clr = 1'b0;
      for (int k = 0; k < N_EN; k++) begin
         if (idx == IDX_W'(W_EN0 + SET_DIST + k)) is_set = 1'b1;
         if (idx == IDX_W'(W_EN0 + CLR_DIST + k)) is_clr = 1'b1;
      end
   end

   always_comb begin
      op = OP_NONE;
      if (wr && in_range) begin
         if (is_set)                              op = OP_SET;
         else if (is_clr)                         op = OP_CLR;
         else if (idx == IDX_W'(W_ERRSTAT))       op = OP_DROP;
         else if (idx == IDX_W'(W_CMD))
            op = (wdata[CMD_HI] || wdata[CMD_LO]) ? OP_SRST : OP_DROP;
         else                                     op = OP_PLAIN;
      end
   end

endmodule

// File: rtl/pen_word_store.sv
`timescale 1ns/1ps
module pen_word_store
   import pen_regs_pkg::*;
#(
   parameter int unsigned          DATA_W  = 32,
   parameter int unsigned          NWORDS  = 128,
   parameter int unsigned          IDX_W   = 7,
   parameter logic [DATA_W-1:0]    VER_RST = 32'hE005_0101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  wr_op_e            op,
   input  logic [IDX_W-1:0]  idx,
   input  logic              in_range,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd,
   output logic [DATA_W-1:0] rdata
);

   if (NWORDS <= W_CMD) $error("bank must reach the command word");

   logic [DATA_W-1:0] words [NWORDS];
   logic              srst;
   assign srst = (op == OP_SRST);

   for (genvar i = 0; i < NWORDS; i++) begin : g_w
      localparam logic [DATA_W-1:0] RV = (i == W_VER) ? VER_RST : '0;
      if (is_zero_word(i)) begin : g_zero
         assign words[i] = '0;
      end else if (is_en_word(i)) begin : g_en
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                            q <= RV;
            else if (srst)                                         q <= RV;
            else if (op == OP_PLAIN && idx == IDX_W'(i))           q <= wdata;
            else if (op == OP_SET && idx == IDX_W'(i + SET_DIST))  q <= q | wdata;
            else if (op == OP_CLR && idx == IDX_W'(i + CLR_DIST))  q <= q & ~wdata;
         end
         assign words[i] = q;
      end else begin : g_plain
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                    q <= RV;
            else if (srst)                                 q <= RV;
            else if (op == OP_PLAIN && idx == IDX_W'(i))   q <= wdata;
         end
         assign words[i] = q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (rd) rdata <= in_range ? words[idx] : '0;
   end

   for (genvar k = 0; k < N_EN; k++) begin : g_chk
      p_set_or_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (op == OP_SET && idx == IDX_W'(W_EN0 + SET_DIST + k)) |=>
            words[W_EN0+k] == ($past(words[W_EN0+k]) | $past(wdata)));
      p_clr_andn_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (op == OP_CLR && idx == IDX_W'(W_EN0 + CLR_DIST + k)) |=>
            words[W_EN0+k] == ($past(words[W_EN0+k]) & ~$past(wdata)));
   end

   p_srst_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (words[W_VER] == VER_RST) && (words[W_EN0] == '0) && (words[W_EN0+1] == '0));

   p_cmd_nostore_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_DROP) |=> $stable(words[W_EN0]) && $stable(words[W_VER]));

   p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> $stable(rdata));

endmodule

// File: rtl/pen_ctrl_regs.sv
`timescale 1ns/1ps
module pen_ctrl_regs
   import pen_regs_pkg::*;
#(
   parameter int unsigned       ADDR_W  = 16,
   parameter int unsigned       DATA_W  = 32,
   parameter int unsigned       NWORDS  = 128,
   parameter logic [DATA_W-1:0] VER_RST = 32'hE005_0101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_rd,
   output logic [DATA_W-1:0] reg_rdata
);

   localparam int unsigned IDX_W = $clog2(NWORDS);

   if ((1 << IDX_W) != NWORDS) $error("NWORDS must be a power of two");
   if (DATA_W < 32)            $error("DATA_W must hold the command bits");

   logic [IDX_W-1:0] dec_idx;
   logic             dec_in_range;
   wr_op_e           dec_op;

   pen_addr_decode #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .NWORDS (NWORDS),
      .IDX_W  (IDX_W),
      .CMD_HI (31),
      .CMD_LO (30)
   ) u_dec (
      .addr     (reg_addr),
      .wr       (reg_wr),
      .wdata    (reg_wdata),
      .idx      (dec_idx),
      .in_range (dec_in_range),
      .op       (dec_op)
   );

   pen_word_store #(
      .DATA_W  (DATA_W),
      .NWORDS  (NWORDS),
      .IDX_W   (IDX_W),
      .VER_RST (VER_RST)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (dec_op),
      .idx      (dec_idx),
      .in_range (dec_in_range),
      .wdata    (reg_wdata),
      .rd       (reg_rd),
      .rdata    (reg_rdata)
   );

   logic rd_alias;
   assign rd_alias = dec_in_range && is_alias(int'(dec_idx));

   p_alias_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && rd_alias) |=> reg_rdata == '0);

   p_errstat_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && dec_in_range && dec_idx == IDX_W'(W_ERRSTAT)) |=> reg_rdata == '0);

   p_oob_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && !dec_in_range) |=> reg_rdata == '0);

   p_oob_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !dec_in_range) |-> dec_op == OP_NONE);

endmodule

// File: tb/pen_ctrl_regs_bench.sv
`timescale 1ns/1ps
module pen_ctrl_regs_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic        reg_rd = 1'b0;
   logic [31:0] reg_rdata;

   always #5 clk = ~clk;

   pen_ctrl_regs u_pen_ctrl_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rd    (reg_rd),
      .reg_rdata (reg_rdata)
   );

   int          n_chk = 0;
   int          n_bad = 0;
   logic [31:0] model [128];
   logic [31:0] exp_q [$];
   string       tag_q [$];
   logic        rd_q = 1'b0;
   logic [31:0] last_rd = '0;

   task automatic model_reset();
      for (int i = 0; i < 128; i++) model[i] = '0;
      model[29] = 32'hE005_0101;
   endtask

   function automatic logic [31:0] model_read(input logic [15:0] a);
      if (a >= 16'h0200) return '0;
      return model[a[8:2]];
   endfunction

   task automatic model_write(input logic [15:0] a, input logic [31:0] d);
      int i;
      if (a >= 16'h0200) return;
      i = int'(a[8:2]);
      case (i)
         4, 5:  model[i] = d;
         6, 7:  model[i-2] = model[i-2] | d;
         8, 9:  model[i-4] = model[i-4] & ~d;
         52:    ;
         116:   if (d[31] || d[30]) model_reset();
         default: model[i] = d;
      endcase
   endtask

   // driver: one access per call, inputs change on the falling edge
   task automatic access(input bit rd, input bit wr, input logic [15:0] a,
                         input logic [31:0] d, input string tag);
      @(negedge clk);
      if (rd) begin
         exp_q.push_back(model_read(a));
         tag_q.push_back(tag);
      end
      if (wr) model_write(a, d);
      reg_addr  = a;
      reg_rd    = rd;
      reg_wr    = wr;
      reg_wdata = d;
      @(negedge clk);
      reg_rd = 1'b0;
      reg_wr = 1'b0;
   endtask

   task automatic wr32(input logic [15:0] a, input logic [31:0] d);
      access(1'b0, 1'b1, a, d, "");
   endtask

   task automatic rd32(input logic [15:0] a, input string tag);
      access(1'b1, 1'b0, a, 32'h0, tag);
   endtask

   // monitor: rd_q marks the edge that captured a read
   always @(posedge clk) rd_q <= reg_rd;

   always @(negedge clk) begin
      if (rd_q) begin
         logic [31:0] e;
         string       t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_chk++;
         last_rd = e;
         if (reg_rdata !== e) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", t, reg_rdata, e);
         end
      end
   end

   task automatic hold_check();
      repeat (3) @(negedge clk);
      n_chk++;
      if (reg_rdata !== last_rd) begin
         n_bad++;
         $display("FAIL R10 hold actual=%08h expected=%08h", reg_rdata, last_rd);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      rd32(16'h0074, "R1 version");
      rd32(16'h0010, "R1 enable0");
      rd32(16'h0014, "R1 enable1");
      rd32(16'h0100, "R1 scratch");

      // R2 direct writes
      wr32(16'h0010, 32'hA5A5_0F0F);
      rd32(16'h0010, "R2 enable0");
      wr32(16'h0014, 32'h0000_FFFF);
      rd32(16'h0014, "R2 enable1");

      // R3 set alias, overlapping mask
      wr32(16'h0018, 32'h00FF_F000);
      rd32(16'h0010, "R3 enable0 set");
      wr32(16'h001C, 32'hF000_00F0);
      rd32(16'h0014, "R3 enable1 set");

      // R4 clear alias, overlapping mask
      wr32(16'h0020, 32'h0F0F_00FF);
      rd32(16'h0010, "R4 enable0 clr");
      wr32(16'h0024, 32'h8000_0F0F);
      rd32(16'h0014, "R4 enable1 clr");

      // R5 alias locations read zero
      rd32(16'h0018, "R5 set0");
      rd32(16'h001C, "R5 set1");
      rd32(16'h0020, "R5 clr0");
      rd32(16'h0024, "R5 clr1");

      // R6 error status discards writes
      wr32(16'h00D0, 32'hFFFF_FFFF);
      rd32(16'h00D0, "R6 errstat");

      // R8 plain storage
      wr32(16'h0040, 32'h1234_5678);
      rd32(16'h0040, "R8 scratch");
      wr32(16'h0074, 32'h0BAD_F00D);
      rd32(16'h0074, "R8 version rw");
      wr32(16'h01FC, 32'hDEAD_BEEF);
      rd32(16'h01FC, "R8 last word");
      wr32(16'h0003, 32'h0000_0077);
      rd32(16'h0000, "R8 word0");

      // R9 out of range
      wr32(16'h0210, 32'hFFFF_FFFF);
      wr32(16'h8040, 32'h5555_5555);
      rd32(16'h0210, "R9 oob read");
      rd32(16'hFFFC, "R9 oob top");
      rd32(16'h0010, "R9 alias unchanged");
      rd32(16'h0040, "R9 scratch unchanged");

      // R10 same-cycle read and write, then hold
      access(1'b1, 1'b1, 16'h0040, 32'hCAFE_0001, "R10 old value");
      rd32(16'h0040, "R10 new value");
      hold_check();

      // R7 command word
      wr32(16'h01D0, 32'h0000_0001);
      rd32(16'h0010, "R7 no-bit write ignored");
      rd32(16'h01D0, "R7 cmd reads zero");
      wr32(16'h01D0, 32'h8000_0000);
      rd32(16'h0010, "R7 bit31 enable0");
      rd32(16'h0074, "R7 bit31 version");
      rd32(16'h0040, "R7 bit31 scratch");
      wr32(16'h0014, 32'h0000_00AA);
      wr32(16'h01FC, 32'h0000_0001);
      wr32(16'h01D0, 32'h4000_0000);
      rd32(16'h0014, "R7 bit30 enable1");
      rd32(16'h01FC, "R7 bit30 last word");
      rd32(16'h01D0, "R7 cmd not stored");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_chk++;
         n_bad++;
         $display("FAIL R10 pending reads actual=%0d expected=0", exp_q.size());
      end
      finish_run();
   end

endmodule